// File: doc/BRIEF.md
# Dual-Class Nested Interrupt Controller

The block gathers level-sensitive interrupt requests from on-chip peripherals plus one software-raised source. It presents them to a processor on two lines: a normal request (`irq_o`) and a fast request (`fiq_o`). Both classes share one 32-bit source map. Bit 1 is the software source, bits 2 to 6 carry the timers and bit 9 is reserved. Each class has a read-only raw view, an enable mask and a masked status view. Bit 0 of the normal raw view summarises the fast line, so a fast event can also be routed as a normal one.

In nesting mode every source carries a 3-bit priority, where 0 is the most urgent. An 8-deep stack records the priority levels in service. Software claims a level by reading the normal status word and releases it by writing the end-of-interrupt word. While a level is held, only sources of strictly more urgent priority can raise `irq_o`. The fast line is never gated.

The register bus is a single-cycle word interface. A write takes effect at the clock edge where `req_i && we_i`. Read data appears on `rdata_o` one cycle after the read request.

Top module: `dc_intc`

## Requirements
- R1: Raw view (word 0x00 normal, 0x08 fast): bit k follows `src_i[k]` level for k not in {0,1,9}. Bit 9 reads 0. Bit 1 is the software source. Fast raw bit 0 reads 0. Normal raw bit 0 equals `fiq_o`.
- R2: Enable mask (read 0x01/0x09) changes only through set (0x02/0x0A) and clear (0x03/0x0B) words: each 1 bit sets or clears that enable bit, each 0 bit has no effect. Status (0x04/0x0C) reads raw AND enable.
- R3: `fiq_o` is 1 exactly when the fast status is nonzero, in the same cycle as the inputs.
- R4: With nesting off (control bit 0 = 0), `irq_o` is 1 exactly when the normal status is nonzero.
- R5: Writing word 0x10 sets the software source to wdata bit 0; it reads back at 0x10 bit 0 and appears at raw bit 1.
- R6: Priorities live in words 0x20 to 0x23. Source k uses word 0x20 + k/8, bits [4*(k%8)+2 : 4*(k%8)]. Reads return that layout with the unused bits as 0.
- R7: With nesting on, `irq_o` is 1 exactly when some normal-status source has a priority numerically lower than the stack top. An empty stack admits any such source.
- R8: With nesting on, a read of 0x04 while normal status is nonzero pushes the lowest priority value among status sources. The depth reads at control word 0x11 bits [11:8].
- R9: Any write to 0x12 pops one level. A pop on an empty stack is ignored.
- R10: A push at depth 8 is ignored and sets the sticky overflow flag (0x11 bit 1). A control write with wdata bit 1 = 1 clears the flag.
- R11: After reset, all enables, the software source, nesting, the priorities, the stack and the overflow flag are 0, and both request outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| src_i | input | 32 | Peripheral request levels in the shared map |
| req_i | input | 1 | Bus access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 6 | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, one cycle after the read request |
| irq_o | output | 1 | Normal request to the processor |
| fiq_o | output | 1 | Fast request to the processor |

## Verification
Raw views are driven with a dense, irregular source word, so that the reserved, software and summary bits can be told apart from ordinary sources. Masking is driven with source words that carry both enabled and disabled bits. This separates an AND with the enable from a plain pass-through, and it exposes zero-bit writes that wrongly change the mask. The nesting sequence mixes two sources of different priority, raised and dropped between claims. This separates a strict comparison against the stack top from a non-strict one, and it shows whether the pushed level is the minimum or merely some pending level. A long run of claims on a priority-0 source drives the stack to full and beyond.

// File: rtl/dc_intc_pkg.sv
package dc_intc_pkg;
  localparam int unsigned ADDR_W = 6;

  localparam logic [ADDR_W-1:0] A_IRQ_RAW = 6'h00;
  localparam logic [ADDR_W-1:0] A_IRQ_EN  = 6'h01;
  localparam logic [ADDR_W-1:0] A_IRQ_SET = 6'h02;
  localparam logic [ADDR_W-1:0] A_IRQ_CLR = 6'h03;
  localparam logic [ADDR_W-1:0] A_IRQ_STS = 6'h04;
  localparam logic [ADDR_W-1:0] A_FIQ_RAW = 6'h08;
  localparam logic [ADDR_W-1:0] A_FIQ_EN  = 6'h09;
  localparam logic [ADDR_W-1:0] A_FIQ_SET = 6'h0A;
  localparam logic [ADDR_W-1:0] A_FIQ_CLR = 6'h0B;
  localparam logic [ADDR_W-1:0] A_FIQ_STS = 6'h0C;
  localparam logic [ADDR_W-1:0] A_SWI     = 6'h10;
  localparam logic [ADDR_W-1:0] A_CTRL    = 6'h11;
  localparam logic [ADDR_W-1:0] A_EOI     = 6'h12;
  localparam logic [ADDR_W-1:0] A_PRIO    = 6'h20;

  localparam int unsigned SWI_BIT  = 1;
  localparam int unsigned RSVD_BIT = 9;
endpackage

// File: rtl/dc_intc_prio_sel.sv
module dc_intc_prio_sel #(
  parameter int unsigned N  = 32,
  parameter int unsigned PW = 3
) (
  input  logic [N-1:0]         vec_i,
  input  logic [N-1:0][PW-1:0] prio_i,
  output logic                 any_o,
  output logic [PW-1:0]        min_o
);
  always_comb begin
    any_o = 1'b0;
    min_o = '1;
    for (int k = 0; k < N; k++) begin
      any_o = any_o | vec_i[k];
      if (vec_i[k] && prio_i[k] < min_o) min_o = prio_i[k];
    end
  end
endmodule

// File: rtl/dc_intc_nest_stack.sv
module dc_intc_nest_stack #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned PW    = 3,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic [PW-1:0] din_i,
  output logic [PW-1:0] top_o,
  output logic          valid_o,
  output logic          full_o,
  output logic [CW-1:0] depth_o
);
  logic [DEPTH-1:0][PW-1:0] mem_q;
  logic [CW-1:0]            cnt_q;

  assign valid_o = (cnt_q != '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign depth_o = cnt_q;
  assign top_o   = valid_o ? mem_q[cnt_q - CW'(1)] : '1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_q <= '0;
      cnt_q <= '0;
    end else if (push_i && !full_o) begin
      mem_q[cnt_q] <= din_i;
      cnt_q        <= cnt_q + CW'(1);
    end else if (pop_i && valid_o) begin
      cnt_q <= cnt_q - CW'(1);
    end
  end
endmodule

// File: rtl/dc_intc.sv
module dc_intc
  import dc_intc_pkg::*;
#(
  parameter int unsigned NSRC  = 32,
  parameter int unsigned PW    = 3,
  parameter int unsigned DEPTH = 8,
  localparam int unsigned CW    = $clog2(DEPTH + 1),
  localparam int unsigned PER_W = 32 / 4,
  localparam int unsigned NPW   = NSRC / PER_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NSRC-1:0]   src_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              irq_o,
  output logic              fiq_o
);
  logic [NSRC-1:0]         irq_en_q, fiq_en_q;
  logic                    swi_q, nest_en_q, ovf_q;
  logic [NSRC-1:0][PW-1:0] prio_q;
  logic [NSRC-1:0]         periph, irq_raw, fiq_raw, irq_sts, fiq_sts, elig;
  logic                    wr, rd, push, pop, sts_any;
  logic [PW-1:0]           sts_min, top;
  logic                    top_vld, full;
  logic [CW-1:0]           depth;
  logic                    unused_src;

  assign wr = req_i && we_i;
  assign rd = req_i && !we_i;

  assign unused_src = ^{src_i[RSVD_BIT], src_i[SWI_BIT], src_i[0]};

  always_comb begin
    periph           = src_i;
    periph[0]        = 1'b0;
    periph[RSVD_BIT] = 1'b0;
    periph[SWI_BIT]  = swi_q;
  end

  assign fiq_raw = periph;
  assign fiq_sts = fiq_raw & fiq_en_q;
  assign fiq_o   = |fiq_sts;
  assign irq_raw = periph | NSRC'(fiq_o);
  assign irq_sts = irq_raw & irq_en_q;

  dc_intc_prio_sel #(.N(NSRC), .PW(PW)) u_sel (
    .vec_i (irq_sts),
    .prio_i(prio_q),
    .any_o (sts_any),
    .min_o (sts_min)
  );

  always_comb
    for (int k = 0; k < NSRC; k++)
      elig[k] = irq_sts[k] && (!top_vld || prio_q[k] < top);

  assign irq_o = nest_en_q ? |elig : |irq_sts;

  assign push = rd && addr_i == A_IRQ_STS && nest_en_q && sts_any;
  assign pop  = wr && addr_i == A_EOI;

  dc_intc_nest_stack #(.DEPTH(DEPTH), .PW(PW)) u_stack (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .push_i (push),
    .pop_i  (pop),
    .din_i  (sts_min),
    .top_o  (top),
    .valid_o(top_vld),
    .full_o (full),
    .depth_o(depth)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_en_q  <= '0;
      fiq_en_q  <= '0;
      swi_q     <= 1'b0;
      nest_en_q <= 1'b0;
      ovf_q     <= 1'b0;
      prio_q    <= '0;
    end else begin
      if (push && full) ovf_q <= 1'b1;
      if (wr) begin
        unique case (addr_i)
          A_IRQ_SET: irq_en_q <= irq_en_q | wdata_i[NSRC-1:0];
          A_IRQ_CLR: irq_en_q <= irq_en_q & ~wdata_i[NSRC-1:0];
          A_FIQ_SET: fiq_en_q <= fiq_en_q | wdata_i[NSRC-1:0];
          A_FIQ_CLR: fiq_en_q <= fiq_en_q & ~wdata_i[NSRC-1:0];
          A_SWI:     swi_q    <= wdata_i[0];
          A_CTRL: begin
            nest_en_q <= wdata_i[0];
            if (wdata_i[1]) ovf_q <= 1'b0;
          end
          default: begin
            for (int w = 0; w < NPW; w++)
              if (addr_i == A_PRIO + ADDR_W'(w))
                for (int k = 0; k < PER_W; k++)
                  prio_q[w*PER_W+k] <= wdata_i[4*k +: PW];
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_o <= '0;
    else if (rd) begin
      rdata_o <= '0;
      unique case (addr_i)
        A_IRQ_RAW: rdata_o <= 32'(irq_raw);
        A_IRQ_EN:  rdata_o <= 32'(irq_en_q);
        A_IRQ_STS: rdata_o <= 32'(irq_sts);
        A_FIQ_RAW: rdata_o <= 32'(fiq_raw);
        A_FIQ_EN:  rdata_o <= 32'(fiq_en_q);
        A_FIQ_STS: rdata_o <= 32'(fiq_sts);
        A_SWI:     rdata_o <= 32'(swi_q);
        A_CTRL:    rdata_o <= {20'd0, 4'(depth), 6'd0, ovf_q, nest_en_q};
        default: begin
          for (int w = 0; w < NPW; w++)
            if (addr_i == A_PRIO + ADDR_W'(w))
              for (int k = 0; k < PER_W; k++)
                rdata_o[4*k +: PW] <= prio_q[w*PER_W+k];
        end
      endcase
    end
  end
endmodule

// File: rtl/dc_intc_chk.sv
module dc_intc_chk #(
  parameter int unsigned NSRC  = 32,
  parameter int unsigned PW    = 3,
  parameter int unsigned DEPTH = 8,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            irq_o,
  input logic            fiq_o,
  input logic            nest_en_q,
  input logic            ovf_q,
  input logic            push,
  input logic            pop,
  input logic            full,
  input logic [CW-1:0]   depth,
  input logic [PW-1:0]   top,
  input logic [NSRC-1:0] irq_raw,
  input logic [NSRC-1:0] fiq_en_q,
  input logic [NSRC-1:0] src_i,
  input logic            wr,
  input logic [5:0]      addr_i,
  input logic [31:0]     wdata_i
);
  // R1
  rsvd_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_raw[9] == 1'b0);

  // R3
  fiq_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fiq_o |-> ((fiq_en_q & (src_i | {{(NSRC-2){1'b0}}, 2'b10})) != '0));

  // R7
  top_zero_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nest_en_q && depth != '0 && top == '0) |-> !irq_o);

  // R8
  push_grow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push && !full) |=> depth == $past(depth) + CW'(1));

  // R9
  pop_shrink_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop && !push && depth != '0) |=> depth == $past(depth) - CW'(1));

  // R10
  depth_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    depth <= CW'(DEPTH));

  // R10
  ovf_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_q && !(wr && addr_i == 6'h11 && wdata_i[1])) |=> ovf_q);
endmodule

bind dc_intc dc_intc_chk #(.NSRC(NSRC), .PW(PW), .DEPTH(DEPTH)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .irq_o    (irq_o),
  .fiq_o    (fiq_o),
  .nest_en_q(nest_en_q),
  .ovf_q    (ovf_q),
  .push     (push),
  .pop      (pop),
  .full     (full),
  .depth    (depth),
  .top      (top),
  .irq_raw  (irq_raw),
  .fiq_en_q (fiq_en_q),
  .src_i    (src_i),
  .wr       (wr),
  .addr_i   (addr_i),
  .wdata_i  (wdata_i)
);

// File: tb/tb_dc_intc.sv
module tb_dc_intc;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] src_i = '0;
  logic        req_i = 1'b0;
  logic        we_i = 1'b0;
  logic [5:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        irq_o, fiq_o;

  int n_chk = 0;
  int n_err = 0;

  always #2 clk_i = ~clk_i;

  dc_intc dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .src_i(src_i), .req_i(req_i),
    .we_i(we_i), .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .irq_o(irq_o), .fiq_o(fiq_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
    @(posedge clk_i);
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b0; addr_i = a;
    @(posedge clk_i);
    @(negedge clk_i);
    req_i = 1'b0;
    d = rdata_o;
  endtask

  task automatic set_src(input logic [31:0] v);
    @(negedge clk_i);
    src_i = v;
    #1;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R11 irq_o", 32'(irq_o), 0);
    chk("R11 fiq_o", 32'(fiq_o), 0);
    rd(6'h01, d); chk("R11 irq enable", d, 0);
    rd(6'h11, d); chk("R11 control", d, 0);
    rd(6'h20, d); chk("R11 priority word", d, 0);
  endtask

  task automatic t_raw();
    logic [31:0] d;
    set_src(32'hA5A5_A7FF);
    rd(6'h00, d); chk("R1 normal raw", d, 32'hA5A5_A5FC);
    rd(6'h08, d); chk("R1 fast raw", d, 32'hA5A5_A5FC);
    set_src(0);
  endtask

  task automatic t_mask();
    logic [31:0] d;
    wr(6'h02, 32'h0000_0F0C);
    rd(6'h01, d); chk("R2 enable after set", d, 32'h0000_0F0C);
    set_src(32'h0000_1004);
    rd(6'h04, d); chk("R2 status masked", d, 32'h4);
    chk("R4 irq_o on", 32'(irq_o), 1);
    wr(6'h03, 32'h4);
    rd(6'h04, d); chk("R2 status after clear", d, 0);
    chk("R4 irq_o off", 32'(irq_o), 0);
    wr(6'h02, 0); wr(6'h03, 0);
    rd(6'h01, d); chk("R2 zero writes no effect", d, 32'h0000_0F08);
    wr(6'h03, 32'hFFFF_FFFF);
    set_src(0);
  endtask

  task automatic t_fiq();
    logic [31:0] d;
    wr(6'h0A, 32'h1000);
    set_src(32'h1000);
    chk("R3 fiq_o on", 32'(fiq_o), 1);
    chk("R4 irq_o masked", 32'(irq_o), 0);
    rd(6'h00, d); chk("R1 summary bit0", d, 32'h1001);
    rd(6'h0C, d); chk("R3 fast status", d, 32'h1000);
    wr(6'h02, 32'h1);
    chk("R3 summary routed to irq_o", 32'(irq_o), 1);
    wr(6'h03, 32'hFFFF_FFFF); wr(6'h0B, 32'hFFFF_FFFF);
    set_src(0);
    chk("R3 fiq_o off", 32'(fiq_o), 0);
  endtask

  task automatic t_swi();
    logic [31:0] d;
    wr(6'h10, 1);
    rd(6'h00, d); chk("R5 software raw bit1", d, 32'h2);
    chk("R5 masked swi", 32'(irq_o), 0);
    wr(6'h02, 32'h2);
    chk("R5 swi irq_o", 32'(irq_o), 1);
    wr(6'h10, 0);
    chk("R5 swi cleared", 32'(irq_o), 0);
    rd(6'h10, d); chk("R5 swi readback", d, 0);
    wr(6'h03, 32'hFFFF_FFFF);
  endtask

  task automatic t_nest();
    logic [31:0] d;
    wr(6'h20, 32'h0205_0000);
    rd(6'h20, d); chk("R6 priority readback", d, 32'h0205_0000);
    wr(6'h02, 32'h50);
    set_src(32'h50);
    wr(6'h11, 1);
    chk("R7 empty stack admits", 32'(irq_o), 1);
    rd(6'h04, d); chk("R8 status read", d, 32'h50);
    rd(6'h11, d); chk("R8 depth one", d, 32'h101);
    chk("R7 level 2 blocks 2 and 5", 32'(irq_o), 0);
    set_src(32'h10);
    chk("R7 level 2 blocks 5", 32'(irq_o), 0);
    wr(6'h12, 0);
    chk("R9 pop re-admits", 32'(irq_o), 1);
    rd(6'h04, d);
    set_src(32'h50);
    chk("R7 prio 2 beats top 5", 32'(irq_o), 1);
    rd(6'h04, d);
    rd(6'h11, d); chk("R8 depth two", d, 32'h201);
    chk("R7 equal level blocked", 32'(irq_o), 0);
    wr(6'h12, 0);
    chk("R7 top 5 after pop", 32'(irq_o), 1);
    wr(6'h12, 0); wr(6'h12, 0);
    rd(6'h11, d); chk("R9 pop on empty ignored", d, 32'h001);
  endtask

  task automatic t_ovf();
    logic [31:0] d;
    wr(6'h03, 32'hFFFF_FFFF);
    wr(6'h02, 32'h4);
    set_src(32'h4);
    chk("R7 prio 0 empty stack", 32'(irq_o), 1);
    for (int i = 0; i < 9; i++) rd(6'h04, d);
    rd(6'h11, d); chk("R10 full and overflow", d, 32'h803);
    chk("R7 top 0 blocks all", 32'(irq_o), 0);
    wr(6'h11, 32'h3);
    rd(6'h11, d); chk("R10 overflow cleared", d, 32'h801);
    wr(6'h11, 0);
    chk("R4 nesting off ignores stack", 32'(irq_o), 1);
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 20000) begin
      @(posedge clk_i);
      cyc++;
    end
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    #1;
    t_reset();
    t_raw();
    t_mask();
    t_fiq();
    t_swi();
    t_nest();
    t_ovf();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule